// File: doc/BRIEF.md
# Systolic Square Tile Transposer

This block rearranges a square tile of DIM x DIM elements with no addressed memory. The data moves physically through a grid of registers. Rows of the tile enter one per accepted beat, and each element travels rightward along the grid row that matches its position inside the incoming row. Once the tile is complete, the whole grid shifts upward one row per accepted output beat. The row leaving the top edge is one column of the original tile. A downstream array that expects the elements of one source row to arrive in the same lane on successive cycles can therefore take a tile straight from row-organised storage.

A pass-through mode sends a tile out unchanged, row by row. In this mode the rows are loaded from the bottom of the grid instead of the left edge, so the fill and drain timing is exactly the same as in the transposing mode. Downstream timing does not depend on the mode. Both edges of the block use a valid/ready handshake. A tile must drain completely before the next one may start loading. While the output is stalled, the entire grid holds its contents.

Top module: `sq_transposer`

## Requirements
- R1: The cycle after reset is released, `in_ready` is 1 and `out_valid` is 0.
- R2: `in_ready` stays high while a tile is filling and stays high after any beat that is not the DIM-th accepted row. When `in_valid` is low during the fill, no row is taken, and gaps of any length leave the result unchanged.
- R3: One cycle after the DIM-th row handshake, `out_valid` is 1 and `in_ready` is 0. `out_valid` then stays high until DIM output beats have been accepted.
- R4: In transpose mode, output beat j (counting from 0) carries element k of that beat at bits [k*W +: W], and this element equals element j of input row k. Element i of an input row sits at bits [i*W +: W].
- R5: In pass-through mode (`in_bypass`=1), element k of output beat j equals element k of input row j. The number of beats and the latency are the same as in R3.
- R6: The mode is taken from `in_bypass` on the first row handshake of a tile. `in_bypass` has no effect on the later rows of that tile.
- R7: When `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_col` is unchanged in the next cycle.
- R8: During the drain `in_ready` is 0, and `in_valid`/`in_row` have no effect on the tile being emitted.
- R9: One cycle after the DIM-th output handshake, `in_ready` is 1 and `out_valid` is 0, so tiles can follow each other with no idle cycle beyond this one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input row offered |
| in_ready | output | 1 | Block can take a row (fill phase) |
| in_bypass | input | 1 | Pass-through request; sampled on the first row of a tile |
| in_row | input | DIM*W | One tile row; element i at bits [i*W +: W] |
| out_valid | output | 1 | Output beat available (drain phase) |
| out_ready | input | 1 | Downstream takes the beat |
| out_col | output | DIM*W | Column of the tile (or row in pass-through); element k at bits [k*W +: W] |

## Verification
The handshake timing is checked by assertions on every cycle: the reset state, the ready flag holding through the fill, the switch to draining exactly one cycle after the DIM-th row, the hand-back to filling after the DIM-th output beat, and the stall freeze of `out_col`. Element placement depends on the data. So the bench checks it: it sends random tiles in both modes and compares every output element with the entry the bench expects from the tile it sent. The bench also covers the cases that only stimulus can exercise. These are fill gaps, a `in_bypass` that toggles on the rows after the first, rows offered during the drain, and tiles sent back to back.

// File: rtl/tpose_pkg.sv
package tpose_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LEFT  = 2'd1,
    OP_BELOW = 2'd2
  } cell_op_e;

  typedef enum logic {
    PH_FILL  = 1'b0,
    PH_DRAIN = 1'b1
  } phase_e;
endpackage

// File: rtl/tpose_cell.sv
module tpose_cell
  import tpose_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  cell_op_e     op,
  input  logic [W-1:0] left_i,
  input  logic [W-1:0] below_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= '0;
    end else begin
      unique case (op)
        OP_LEFT:  q_o <= left_i;
        OP_BELOW: q_o <= below_i;
        default:  q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/tpose_ctrl.sv
module tpose_ctrl
  import tpose_pkg::*;
#(
  parameter int DIM = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     in_valid,
  input  logic     in_bypass,
  input  logic     out_ready,
  output logic     in_ready,
  output logic     out_valid,
  output logic     feed_zero,
  output cell_op_e op
);
  localparam int CW = (DIM > 1) ? $clog2(DIM) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIM - 1);

  phase_e        phase_q;
  logic [CW-1:0] cnt_q;
  logic          byp_q;
  logic          take_row;
  logic          give_col;
  logic          mode_now;

  assign in_ready  = (phase_q == PH_FILL);
  assign out_valid = (phase_q == PH_DRAIN);
  assign feed_zero = (phase_q == PH_DRAIN);
  assign take_row  = in_ready && in_valid;
  assign give_col  = out_valid && out_ready;
  // the first row of a tile picks the mode; later rows reuse the stored one
  assign mode_now  = (cnt_q == '0) ? in_bypass : byp_q;

  always_comb begin
    op = OP_HOLD;
    if (take_row)      op = mode_now ? OP_BELOW : OP_LEFT;
    else if (give_col) op = OP_BELOW;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_FILL;
      cnt_q   <= '0;
      byp_q   <= 1'b0;
    end else if (take_row) begin
      if (cnt_q == '0) byp_q <= in_bypass;
      if (cnt_q == LAST) begin
        cnt_q   <= '0;
        phase_q <= PH_DRAIN;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (give_col) begin
      if (cnt_q == LAST) begin
        cnt_q   <= '0;
        phase_q <= PH_FILL;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sq_transposer.sv
module sq_transposer
  import tpose_pkg::*;
#(
  parameter int DIM = 4,
  parameter int W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bypass,
  input  logic [DIM*W-1:0] in_row,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DIM*W-1:0] out_col
);
  cell_op_e     op;
  logic         feed_zero;
  logic [W-1:0] grid [DIM][DIM];

  tpose_ctrl #(.DIM(DIM)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_bypass (in_bypass),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .feed_zero (feed_zero),
    .op        (op)
  );

  for (genvar r = 0; r < DIM; r++) begin : g_row
    for (genvar c = 0; c < DIM; c++) begin : g_col
      logic [W-1:0] left_d;
      logic [W-1:0] below_d;

      if (c == 0) begin : g_edge_l
        assign left_d = in_row[r*W +: W];
      end else begin : g_inner_l
        assign left_d = grid[r][c-1];
      end

      if (r == DIM - 1) begin : g_edge_b
        // pass-through rows enter reversed so the output tap is shared
        assign below_d = feed_zero ? '0 : in_row[(DIM-1-c)*W +: W];
      end else begin : g_inner_b
        assign below_d = grid[r+1][c];
      end

      tpose_cell #(.W(W)) u_cell (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .left_i  (left_d),
        .below_i (below_d),
        .q_o     (grid[r][c])
      );
    end
  end

  for (genvar k = 0; k < DIM; k++) begin : g_out
    assign out_col[k*W +: W] = grid[0][DIM-1-k];
  end
endmodule

// File: rtl/tpose_checker.sv
module tpose_checker #(
  parameter int DIM = 4,
  parameter int W   = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [DIM*W-1:0] out_col
);
  localparam int CW = $clog2(DIM) + 1;

  logic [CW-1:0] acc_cnt;
  logic [CW-1:0] drn_cnt;
  logic          rst_q = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      acc_cnt <= '0;
      drn_cnt <= '0;
    end else begin
      if (in_valid && in_ready)
        acc_cnt <= (acc_cnt == CW'(DIM - 1)) ? '0 : acc_cnt + 1'b1;
      if (out_valid && out_ready)
        drn_cnt <= (drn_cnt == CW'(DIM - 1)) ? '0 : drn_cnt + 1'b1;
    end
  end

  always @(posedge clk) begin
    if (rst_q && !rst) begin
      p_reset_state_r1: assert (in_ready && !out_valid)
        else $error("reset state wrong");
    end
  end

  p_fill_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !(in_valid && acc_cnt == CW'(DIM - 1))) |=> in_ready);

  p_fill_done_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && acc_cnt == CW'(DIM - 1)) |=> (out_valid && !in_ready));

  p_drain_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !(out_ready && drn_cnt == CW'(DIM - 1))) |=> out_valid);

  p_stall_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_col)));

  p_drain_done_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && drn_cnt == CW'(DIM - 1)) |=> (in_ready && !out_valid));
endmodule

bind sq_transposer tpose_checker #(.DIM(DIM), .W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_col   (out_col)
);

// File: tb/sq_transposer_test.sv
`timescale 1ns/1ps
module sq_transposer_test;
  localparam int DIM = 4;
  localparam int W   = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic             in_bypass = 1'b0;
  logic [DIM*W-1:0] in_row = '0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [DIM*W-1:0] out_col;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] tile [DIM][DIM];

  always #2 clk = ~clk;

  sq_transposer #(.DIM(DIM), .W(W)) uut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expect_el(input bit byp, input int j, input int k);
    return byp ? tile[j][k] : tile[k][j];
  endfunction

  // gaps: random idle beats; flip: toggle in_bypass after first row
  task automatic run_tile(input bit byp, input bit gaps, input bit flip, input bit stalls);
    int acc = 0;
    int beat = 0;
    logic [DIM*W-1:0] held;
    bit was_stall = 0;
    for (int r = 0; r < DIM; r++)
      for (int c = 0; c < DIM; c++) tile[r][c] = W'($urandom);
    while (acc < DIM) begin
      @(negedge clk);
      check(in_ready == 1'b1 && out_valid == 1'b0, "R2", "ready during fill",
            {in_ready, out_valid}, 2'b10);
      in_valid  = !(gaps && ($urandom % 3 == 0));
      in_bypass = (acc == 0) ? byp : (flip ? ~byp : byp);
      for (int k = 0; k < DIM; k++) in_row[k*W +: W] = tile[acc][k];
      if (in_valid) acc++;
    end
    @(negedge clk);
    // R3: drain starts one cycle after the last row; R8: junk offered now
    check(out_valid == 1'b1 && in_ready == 1'b0, "R3", "fill to drain",
          {out_valid, in_ready}, 2'b10);
    in_valid = 1'b1;
    in_bypass = ~byp;
    in_row = {DIM{8'hA5}};
    while (beat < DIM) begin
      if (!out_valid) begin
        check(0, "R3", "valid dropped in drain", out_valid, 1);
        return;
      end
      check(in_ready == 1'b0, "R8", "ready low in drain", in_ready, 0);
      if (was_stall)
        check(out_col == held, "R7", "stall hold", out_col, held);
      out_ready = !(stalls && ($urandom % 2 == 0));
      for (int k = 0; k < DIM; k++)
        check(out_col[k*W +: W] == expect_el(byp, beat, k), byp ? "R5" : "R4",
              $sformatf("beat %0d el %0d", beat, k),
              out_col[k*W +: W], expect_el(byp, beat, k));
      held = out_col;
      was_stall = !out_ready;
      if (out_ready) beat++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 1'b0;
    check(in_ready == 1'b1 && out_valid == 1'b0, "R9", "drain to fill",
          {in_ready, out_valid}, 2'b10);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL R3 watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1", "reset state",
          {in_ready, out_valid}, 2'b10);
    // directed corners
    run_tile(0, 0, 0, 0);          // R4 plain transpose, back to back
    run_tile(1, 0, 0, 0);          // R5 pass-through
    run_tile(0, 0, 1, 0);          // R6 bypass toggles after first row
    run_tile(1, 0, 1, 0);          // R6 other polarity
    run_tile(0, 1, 0, 1);          // R2 gaps, R7 stalls
    for (int t = 0; t < 40; t++)
      run_tile($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule